// File: doc/BRIEF.md
# DDR Burst SRAM Command Scheduler

This block sits on the controller side of a burst-of-two DDR SRAM. It accepts read and write requests from a valid/ready user port and turns them into memory commands: an active-low load strobe, a read/write select, an address, and, for writes, a pair of data words, each with its own active-low byte selects. Requests are served strictly in arrival order. Reads or writes of the same kind stream out on every clock. A write that follows a read is held back until the memory has seen the idle cycles it needs to turn its data bus around: one idle cycle by default, and two when the high-frequency option is set. A read that follows a write goes out at once.

Each read command makes the memory return a pair of words after a fixed latency, and the scheduler always collects that pair. The pair is captured at a clock edge picked by the latency mode input. It is handed back to the user with the tag that came with the request. Tags of reads in flight wait in a small in-order queue, so every returned pair meets the right tag. Both configuration inputs are static straps. They are changed only while nothing is in flight.

Top module: `ddr_burst_sched`

## Requirements
- R1: A request accepted at a clock edge appears on the memory pins for the following cycle. A read drives `mem_ld_n`=0 and `mem_rw`=1, a write drives `mem_ld_n`=0 and `mem_rw`=0, and a cycle with no command drives `mem_ld_n`=1. `mem_addr` carries the request address in the command cycle.
- R2: Between a read command and a following write command there is at least one cycle with `mem_ld_n`=1. With `cfg_extra_gap`=0, a write waiting behind a read goes out exactly two cycles after the read command.
- R3: With `cfg_extra_gap`=1 there are at least two idle cycles on that turnaround, and a waiting write goes out exactly three cycles after the read command.
- R4: Back-to-back reads, or back-to-back writes, issue commands on consecutive cycles. A read that follows a write issues in the very next cycle, with no idle cycle.
- R5: In the cycle after a write command, `mem_d0`/`mem_d1` carry the first and second data words. `mem_bw0_n`/`mem_bw1_n` carry the inverted byte enables of those words, where bit k covers bits 8k+7..8k. In every other cycle both byte-select buses are all ones.
- R6: With `cfg_long_lat`=0, the word pair on `mem_q0`/`mem_q1` is captured at the clock edge that ends the cycle after the read command, and `rsp_valid` is high two cycles after the command cycle. With `cfg_long_lat`=1, capture is one edge later and `rsp_valid` is high three cycles after the command cycle.
- R7: Every accepted read gives exactly one response, in request order, with its own tag and the pair of words the memory returned. No read is ever dropped.
- R8: `req_ready` is low while a write waits for turnaround idle cycles. It is high otherwise while the tag queue has room.
- R9: After reset, no command is driven (`mem_ld_n`=1), byte selects are all ones, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_extra_gap | input | 1 | Add a second idle cycle on read-to-write turnaround |
| cfg_long_lat | input | 1 | 1: 1.5-cycle read latency, 0: 1-cycle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Burst address |
| req_tag | input | TW | Tag returned with read data |
| req_wdata0 | input | DW | First write word |
| req_wdata1 | input | DW | Second write word |
| req_be0 | input | DW/8 | Byte enables of first word, active high |
| req_be1 | input | DW/8 | Byte enables of second word, active high |
| mem_ld_n | output | 1 | Load strobe, active low |
| mem_rw | output | 1 | 1 read, 0 write |
| mem_addr | output | AW | Command address |
| mem_d0 | output | DW | First write word |
| mem_d1 | output | DW | Second write word |
| mem_bw0_n | output | DW/8 | Byte selects of first word, active low |
| mem_bw1_n | output | DW/8 | Byte selects of second word, active low |
| mem_q0 | input | DW | First returned read word |
| mem_q1 | input | DW | Second returned read word |
| rsp_valid | output | 1 | Read response present |
| rsp_tag | output | TW | Tag of the response |
| rsp_data0 | output | DW | First response word |
| rsp_data1 | output | DW | Second response word |

## Verification
The assertions assume that both configuration straps stay steady while any read is in flight, and that the memory places each returned pair on `mem_q0`/`mem_q1` in the cycle before the capture edge set by the latency mode. The bench changes straps only after the scoreboard has drained and the bus has idled. Its memory model is driven from the command pins and follows the same capture rule. Request payloads stay stable while `req_ready` is low, which the scoreboard relies on to predict data.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;
    // capture depth, in clock edges after the acceptance edge
    localparam int LAT_SHORT_EDGES = 2;
    localparam int LAT_LONG_EDGES  = 3;
    // idle cycles required on read-to-write turnaround
    localparam int TURN_BASE  = 1;
    localparam int TURN_EXTRA = 1;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/ddrs_tag_fifo.sv
module ddrs_tag_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (push) begin
            f_d.slot[f_q.wp] = din;
            f_d.wp = (f_q.wp == PW'(DEPTH - 1)) ? '0 : f_q.wp + PW'(1);
        end
        if (pop) begin
            f_d.rp = (f_q.rp == PW'(DEPTH - 1)) ? '0 : f_q.rp + PW'(1);
        end
        case ({push, pop})
            2'b10:   f_d.cnt = f_q.cnt + CW'(1);
            2'b01:   f_d.cnt = f_q.cnt - CW'(1);
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign dout  = f_q.slot[f_q.rp];
    assign full  = (f_q.cnt == CW'(DEPTH));
    assign empty = (f_q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));  // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R7
endmodule

// File: rtl/ddrs_turn_guard.sv
module ddrs_turn_guard
    import ddr_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic extra_gap,
    input  logic fire_rd,
    input  logic fire_wr,
    output logic wr_block
);
    localparam int MAXGAP = TURN_BASE + TURN_EXTRA;
    localparam int CW     = $clog2(MAXGAP + 1);

    typedef struct packed {
        logic          after_rd;
        logic [CW-1:0] idles;
    } turn_t;

    turn_t t_d, t_q;
    logic [CW-1:0] need;

    always_comb begin
        t_d = t_q;
        if (fire_rd) begin
            t_d.after_rd = 1'b1;
            t_d.idles    = '0;
        end else if (fire_wr) begin
            t_d.after_rd = 1'b0;
            t_d.idles    = '0;
        end else if (t_q.idles != CW'(MAXGAP)) begin
            t_d.idles = t_q.idles + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign need     = extra_gap ? CW'(MAXGAP) : CW'(TURN_BASE);
    assign wr_block = t_q.after_rd && (t_q.idles < need);
endmodule

// File: rtl/ddrs_rd_return.sv
module ddrs_rd_return
    import ddr_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic long_lat,
    input  logic fire_rd,
    output logic capture
);
    typedef struct packed {
        logic [LAT_LONG_EDGES-1:0] flight;
    } ret_t;

    ret_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.flight = {r_q.flight[LAT_LONG_EDGES-2:0], fire_rd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign capture = long_lat ? r_q.flight[LAT_LONG_EDGES-1]
                              : r_q.flight[LAT_SHORT_EDGES-1];
endmodule

// File: rtl/ddr_burst_sched.sv
module ddr_burst_sched
    import ddr_sched_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 16,
    parameter int TW     = 4,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_extra_gap,
    input  logic              cfg_long_lat,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [TW-1:0]     req_tag,
    input  logic [DW-1:0]     req_wdata0,
    input  logic [DW-1:0]     req_wdata1,
    input  logic [DW/8-1:0]   req_be0,
    input  logic [DW/8-1:0]   req_be1,
    output logic              mem_ld_n,
    output logic              mem_rw,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_d0,
    output logic [DW-1:0]     mem_d1,
    output logic [DW/8-1:0]   mem_bw0_n,
    output logic [DW/8-1:0]   mem_bw1_n,
    input  logic [DW-1:0]     mem_q0,
    input  logic [DW-1:0]     mem_q1,
    output logic              rsp_valid,
    output logic [TW-1:0]     rsp_tag,
    output logic [DW-1:0]     rsp_data0,
    output logic [DW-1:0]     rsp_data1
);
    localparam int BW = DW / 8;

    typedef struct packed {
        logic          ld_n;
        logic          rw;
        logic [AW-1:0] addr;
        logic          stg_v;
        logic [DW-1:0] stg_d0;
        logic [DW-1:0] stg_d1;
        logic [BW-1:0] stg_be0;
        logic [BW-1:0] stg_be1;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
        logic [BW-1:0] bw0_n;
        logic [BW-1:0] bw1_n;
        logic          rsp_v;
        logic [TW-1:0] rsp_tag;
        logic [DW-1:0] rsp_d0;
        logic [DW-1:0] rsp_d1;
    } sched_t;

    sched_t s_d, s_q;

    logic          wr_block;
    logic          tag_full;
    logic          tag_empty;
    logic [TW-1:0] tag_head;
    logic          capture;
    logic          fire;
    logic          fire_rd;
    logic          fire_wr;
    op_e           op;

    assign req_ready = req_write ? !wr_block : !tag_full;
    assign fire      = req_valid && req_ready;
    assign fire_rd   = fire && !req_write;
    assign fire_wr   = fire && req_write;

    always_comb begin
        if (fire_wr)      op = OP_WRITE;
        else if (fire_rd) op = OP_READ;
        else              op = OP_NONE;
    end

    ddrs_turn_guard u_turn (
        .clk       (clk),
        .rst_n     (rst_n),
        .extra_gap (cfg_extra_gap),
        .fire_rd   (fire_rd),
        .fire_wr   (fire_wr),
        .wr_block  (wr_block)
    );

    ddrs_tag_fifo #(.W(TW), .DEPTH(QDEPTH)) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fire_rd),
        .din   (req_tag),
        .pop   (capture),
        .dout  (tag_head),
        .full  (tag_full),
        .empty (tag_empty)
    );

    ddrs_rd_return u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .long_lat (cfg_long_lat),
        .fire_rd  (fire_rd),
        .capture  (capture)
    );

    always_comb begin
        s_d = s_q;
        // command slot
        case (op)
            OP_READ: begin
                s_d.ld_n = 1'b0;
                s_d.rw   = 1'b1;
                s_d.addr = req_addr;
            end
            OP_WRITE: begin
                s_d.ld_n = 1'b0;
                s_d.rw   = 1'b0;
                s_d.addr = req_addr;
            end
            default: begin
                s_d.ld_n = 1'b1;
                s_d.rw   = 1'b1;
            end
        endcase
        // write data staged one cycle behind its command
        s_d.stg_v = (op == OP_WRITE);
        if (op == OP_WRITE) begin
            s_d.stg_d0  = req_wdata0;
            s_d.stg_d1  = req_wdata1;
            s_d.stg_be0 = req_be0;
            s_d.stg_be1 = req_be1;
        end
        if (s_q.stg_v) begin
            s_d.d0    = s_q.stg_d0;
            s_d.d1    = s_q.stg_d1;
            s_d.bw0_n = ~s_q.stg_be0;
            s_d.bw1_n = ~s_q.stg_be1;
        end else begin
            s_d.d0    = '0;
            s_d.d1    = '0;
            s_d.bw0_n = '1;
            s_d.bw1_n = '1;
        end
        // read return
        s_d.rsp_v = capture;
        if (capture) begin
            s_d.rsp_tag = tag_head;
            s_d.rsp_d0  = mem_q0;
            s_d.rsp_d1  = mem_q1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ld_n  <= 1'b1;
            s_q.rw    <= 1'b1;
            s_q.bw0_n <= '1;
            s_q.bw1_n <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_ld_n  = s_q.ld_n;
    assign mem_rw    = s_q.rw;
    assign mem_addr  = s_q.addr;
    assign mem_d0    = s_q.d0;
    assign mem_d1    = s_q.d1;
    assign mem_bw0_n = s_q.bw0_n;
    assign mem_bw1_n = s_q.bw1_n;
    assign rsp_valid = s_q.rsp_v;
    assign rsp_tag   = s_q.rsp_tag;
    assign rsp_data0 = s_q.rsp_d0;
    assign rsp_data1 = s_q.rsp_d1;

    logic rd_on_pins;
    logic wr_on_pins;
    assign rd_on_pins = !mem_ld_n && mem_rw;
    assign wr_on_pins = !mem_ld_n && !mem_rw;

    AST_TURN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_on_pins |-> !$past(rd_on_pins));  // R2
    AST_TURN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_on_pins && cfg_extra_gap) |-> !$past(rd_on_pins, 2));  // R3
    AST_BW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_on_pins) |-> (&mem_bw0_n && &mem_bw1_n));  // R5
    AST_RSP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !cfg_long_lat) |-> $past(rd_on_pins, 2));  // R6
    AST_RSP_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cfg_long_lat) |-> $past(rd_on_pins, 3));  // R6
    AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && rd_on_pins) |-> !req_ready);  // R8
    AST_RSP_HAS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !tag_empty);  // R7
endmodule

// File: tb/ddr_burst_sched_bench.sv
`timescale 1ns/1ps
module ddr_burst_sched_bench;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int TW = 4;
    localparam int BW = DW / 8;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_extra_gap = 1'b0;
    logic cfg_long_lat = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [TW-1:0] req_tag = '0;
    logic [DW-1:0] req_wdata0 = '0, req_wdata1 = '0;
    logic [BW-1:0] req_be0 = '0, req_be1 = '0;
    logic mem_ld_n, mem_rw;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_d0, mem_d1;
    logic [BW-1:0] mem_bw0_n, mem_bw1_n;
    logic [DW-1:0] mem_q0 = '0, mem_q1 = '0;
    logic rsp_valid;
    logic [TW-1:0] rsp_tag;
    logic [DW-1:0] rsp_data0, rsp_data1;

    always #10 clk = ~clk;

    ddr_burst_sched u_ddr_burst_sched (.*);

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [2*DW-1:0] ref_mem [NW];
    logic [2*DW-1:0] sram [NW];

    typedef struct packed { logic [TW-1:0] tag; logic [2*DW-1:0] data; } rsp_t;
    typedef struct packed { logic [DW-1:0] d0; logic [DW-1:0] d1; logic [BW-1:0] be0; logic [BW-1:0] be1; } wr_t;
    rsp_t exp_q[$];
    wr_t  wexp_q[$];
    int   rcyc_q[$];

    int last_waits = 0;
    int last_rd_cyc = 0, last_wr_cyc = 0, first_rd_cyc = 0, first_wr_cyc = 0;
    int rd_cnt = 0, wr_cnt = 0;
    bit arm_rd = 0, arm_wr = 0;
    logic [TW-1:0] tag_ctr = '0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [2*DW-1:0] merge(input logic [2*DW-1:0] old,
            input logic [DW-1:0] w0, input logic [DW-1:0] w1,
            input logic [BW-1:0] b0, input logic [BW-1:0] b1);
        logic [2*DW-1:0] r = old;
        for (int k = 0; k < BW; k++) begin
            if (b0[k]) r[8*k +: 8] = w0[8*k +: 8];
            if (b1[k]) r[DW + 8*k +: 8] = w1[8*k +: 8];
        end
        return r;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // driver: called at a falling edge, returns at the falling edge after acceptance
    task automatic do_req(input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                          input logic [BW-1:0] b0, input logic [BW-1:0] b1);
        int waits = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_tag = tag_ctr;
        req_wdata0 = w0; req_wdata1 = w1; req_be0 = b0; req_be1 = b1;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1; waits++;
        end
        if (wr) begin
            ref_mem[a] = merge(ref_mem[a], w0, w1, b0, b1);
            wexp_q.push_back('{d0: w0, d1: w1, be0: b0, be1: b1});
        end else begin
            exp_q.push_back('{tag: tag_ctr, data: ref_mem[a]});
            tag_ctr = tag_ctr + 1'b1;
        end
        @(negedge clk);
        last_waits = waits;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        req_valid = 1'b0;
        while (exp_q.size() != 0 || wexp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // memory model driven from the command pins
    bit wpend = 0;
    logic [AW-1:0] waddr;
    bit rp0_v = 0, rp1_v = 0;
    logic [AW-1:0] rp0_a, rp1_a;
    always @(negedge clk) begin
        if (wpend) begin
            sram[waddr] = merge(sram[waddr], mem_d0, mem_d1, ~mem_bw0_n, ~mem_bw1_n);
            wpend = 0;
        end
        if (rst_n && !mem_ld_n && !mem_rw) begin
            wpend = 1; waddr = mem_addr;
        end
        if (cfg_long_lat ? rp1_v : rp0_v)
            {mem_q1, mem_q0} = sram[cfg_long_lat ? rp1_a : rp0_a];
        else
            {mem_q1, mem_q0} = 32'hDEAD_BEEF;
        rp1_v = rp0_v; rp1_a = rp0_a;
        rp0_v = rst_n && !mem_ld_n && mem_rw; rp0_a = mem_addr;
    end

    // monitor / scoreboard
    bit wr_prev = 0;
    bit last_was_rd = 0;
    int last_cmd_cyc = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit rd, wr;
            rd = !mem_ld_n && mem_rw;
            wr = !mem_ld_n && !mem_rw;
            if (wr_prev) begin
                wr_t w;
                if (wexp_q.size() == 0) chk(0, "R5", "unexpected write data", 0, 1);
                else begin
                    w = wexp_q.pop_front();
                    chk(mem_d0 == w.d0, "R5", "word0", mem_d0, w.d0);
                    chk(mem_d1 == w.d1, "R5", "word1", mem_d1, w.d1);
                    chk(mem_bw0_n == ~w.be0, "R5", "bw0_n", mem_bw0_n, ~w.be0);
                    chk(mem_bw1_n == ~w.be1, "R5", "bw1_n", mem_bw1_n, ~w.be1);
                end
            end else begin
                chk(&mem_bw0_n && &mem_bw1_n, "R5", "idle byte selects",
                    {mem_bw1_n, mem_bw0_n}, {2*BW{1'b1}});
            end
            if (rsp_valid) begin
                rsp_t e;
                int c;
                if (exp_q.size() == 0) chk(0, "R7", "unexpected response", 0, 1);
                else begin
                    e = exp_q.pop_front();
                    c = rcyc_q.pop_front();
                    chk(rsp_tag == e.tag, "R7", "tag", rsp_tag, e.tag);
                    chk({rsp_data1, rsp_data0} == e.data, "R7", "data",
                        {rsp_data1, rsp_data0}, e.data);
                    chk(cyc - c == (cfg_long_lat ? 3 : 2), "R6", "latency",
                        cyc - c, cfg_long_lat ? 3 : 2);
                end
            end
            if (wr && last_was_rd) begin
                int need = cfg_extra_gap ? 2 : 1;
                chk(cyc - last_cmd_cyc - 1 >= need, cfg_extra_gap ? "R3" : "R2",
                    "turnaround idles", cyc - last_cmd_cyc - 1, need);
            end
            if (rd) begin
                rcyc_q.push_back(cyc);
                rd_cnt++; last_rd_cyc = cyc;
                if (arm_rd) begin first_rd_cyc = cyc; arm_rd = 0; end
            end
            if (wr) begin
                wr_cnt++; last_wr_cyc = cyc;
                if (arm_wr) begin first_wr_cyc = cyc; arm_wr = 0; end
            end
            if (rd || wr) begin
                last_was_rd = rd; last_cmd_cyc = cyc;
            end
            wr_prev = wr;
        end
    end

    task automatic turnaround_test(input logic [AW-1:0] a);
        int need = cfg_extra_gap ? 2 : 1;
        idle(2);
        do_req(0, a, 0, 0, 0, 0);
        do_req(1, a + 1, 16'h1234 + DW'(a), 16'h5678, 2'b11, 2'b01);
        idle(4);
        chk(last_wr_cyc - last_rd_cyc == need + 1, cfg_extra_gap ? "R3" : "R2",
            "read-to-write spacing", last_wr_cyc - last_rd_cyc, need + 1);
        chk(last_waits == need, "R8", "ready low cycles", last_waits, need);
        do_req(1, a + 2, 16'hA5A5, 16'h0F0F, 2'b10, 2'b11);
        do_req(0, a + 2, 0, 0, 0, 0);
        idle(4);
        chk(last_rd_cyc - last_wr_cyc == 1, "R4", "write-to-read spacing",
            last_rd_cyc - last_wr_cyc, 1);
        chk(last_waits == 0, "R8", "ready on write-to-read", last_waits, 0);
    endtask

    task automatic stream_test(input bit wr, input logic [AW-1:0] a);
        int base = wr ? wr_cnt : rd_cnt;
        idle(2);
        if (wr) arm_wr = 1; else arm_rd = 1;
        for (int i = 0; i < 4; i++)
            do_req(wr, a + AW'(i), 16'h3000 + DW'(i), 16'h4000 + DW'(i), 2'b11, 2'b11);
        idle(4);
        if (wr) begin
            chk(wr_cnt - base == 4, "R4", "write stream count", wr_cnt - base, 4);
            chk(last_wr_cyc - first_wr_cyc == 3, "R4", "write stream spacing",
                last_wr_cyc - first_wr_cyc, 3);
        end else begin
            chk(rd_cnt - base == 4, "R4", "read stream count", rd_cnt - base, 4);
            chk(last_rd_cyc - first_rd_cyc == 3, "R4", "read stream spacing",
                last_rd_cyc - first_rd_cyc, 3);
        end
    endtask

    task automatic random_mix(input int n);
        for (int i = 0; i < n; i++) begin
            if ($urandom % 8 == 0) idle(1 + $urandom % 3);
            do_req($urandom % 2, AW'($urandom % 16), DW'($urandom), DW'($urandom),
                   BW'($urandom), BW'($urandom));
        end
        drain();
    endtask

    // R1 command encoding and address, checked on the pins one cycle after acceptance
    task automatic encoding_test();
        idle(2);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h3C; req_tag = tag_ctr;
        #1;
        exp_q.push_back('{tag: tag_ctr, data: ref_mem[8'h3C]});
        tag_ctr = tag_ctr + 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_ld_n == 0 && mem_rw == 1, "R1", "read encoding", {mem_ld_n, mem_rw}, 2'b01);
        chk(mem_addr == 8'h3C, "R1", "read address", mem_addr, 8'h3C);
        @(negedge clk);
        chk(mem_ld_n == 1, "R1", "idle encoding", mem_ld_n, 1);
        idle(3);
        do_req(1, 8'h41, 16'hBEEF, 16'hCAFE, 2'b01, 2'b10);
        req_valid = 1'b0;
        chk(mem_ld_n == 0 && mem_rw == 0, "R1", "write encoding", {mem_ld_n, mem_rw}, 2'b00);
        chk(mem_addr == 8'h41, "R1", "write address", mem_addr, 8'h41);
        idle(3);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            ref_mem[i] = {16'(i * 7 + 3), 16'(i * 13 + 1)};
            sram[i]    = ref_mem[i];
        end
        repeat (3) @(negedge clk);
        chk(mem_ld_n == 1, "R9", "reset ld_n", mem_ld_n, 1);
        chk(rsp_valid == 0, "R9", "reset rsp_valid", rsp_valid, 0);
        chk(&mem_bw0_n && &mem_bw1_n, "R9", "reset byte selects",
            {mem_bw1_n, mem_bw0_n}, {2*BW{1'b1}});
        chk(req_ready == 1, "R9", "reset ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        cfg_extra_gap = 0; cfg_long_lat = 0;
        encoding_test();
        stream_test(1, 8'h10);
        stream_test(0, 8'h10);
        turnaround_test(8'h20);
        random_mix(150);

        cfg_extra_gap = 1; cfg_long_lat = 1;
        @(negedge clk);
        turnaround_test(8'h30);
        stream_test(0, 8'h20);
        random_mix(150);

        cfg_extra_gap = 0; cfg_long_lat = 1;
        @(negedge clk);
        turnaround_test(8'h40);
        random_mix(100);

        cfg_extra_gap = 1; cfg_long_lat = 0;
        @(negedge clk);
        turnaround_test(8'h50);
        random_mix(100);

        chk(exp_q.size() == 0, "R7", "reads left without response", exp_q.size(), 0);
        chk(wexp_q.size() == 0, "R5", "writes left without data", wexp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cyc > 100000) begin
            done = 1;
            total++; bad++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule